// File: doc/BRIEF.md
# Four-Slot Pulse-Position Chip Aligner and Byte Decoder

This block sits behind the timing-recovery stage of a four-slot pulse-position receiver. It gets one sampled timeslot bit at a time, each tagged with the 2-bit slot index that timing recovery gives it, and builds these into four-slot chips. A chip is complete when a slot with index 3 arrives. At first the chip boundary is arbitrary. The block gathers groups of four chips and compares each group with the preamble. After each failed group it asks timing recovery to slip its slot count by one slot. This repeats until a group matches.

Once locked on the preamble, the block follows the repeating preamble for as long as it lasts. It then checks an eight-chip start flag and decodes every following group of four chips into one byte. A stop flag closes the frame. Any malformed chip in the start flag, the data or the stop flag ends the frame with a framing-error pulse. After any frame end the block goes back to hunting. CRC checking, address filtering and storage are done by later blocks.

Top module: `ppm4_hunt_decoder`

## Requirements
- R1: After reset, and on every cycle where `en` is low, all pulse outputs are low and the block is in hunt with empty chip and group state; slots presented while `en` is low have no effect.
- R2: In hunt, the block compares each group of four completed chips with the preamble 1000 0000 1010 1000 (each chip written as slot0 slot1 slot2 slot3, a 1 meaning a pulse). On a mismatch, `slip` pulses for one cycle in the cycle after the slot with index 3 that completed the fourth chip, and a new group starts with the next chip.
- R3: On a preamble match, `slot_rst` pulses for one cycle, in the same cycle position as `slip` would. The block then stays locked through any number of further preamble repeats and gives no pulse while it does so.
- R4: While locked, a 0000 chip at a preamble group boundary starts the start flag 0000 1100 0000 1100 0110 0000 0110 0000. `sof` pulses one cycle after its eighth chip completes.
- R5: Any start-flag chip that does not match raises a one-cycle `frm_err` and returns the block to hunt.
- R6: In a frame, a chip with its single pulse in slot k (k = 0 to 3) carries the bit pair k. The first chip of a group fills bits 1:0 and the fourth fills bits 7:6. `byte_vld` pulses with `byte_data` one cycle after the fourth chip completes.
- R7: A data chip with zero pulses or more than one pulse raises `frm_err` and returns the block to hunt. The only exception is a 0000 chip at a byte boundary.
- R8: A 0000 chip at a byte boundary starts the stop flag 0000 1100 0000 1100 0000 0110 0000 0110. After its eighth chip, `eof` pulses for one cycle and the block returns to hunt.
- R9: Any stop-flag chip that does not match raises `frm_err` and returns the block to hunt.
- R10: At most one of `byte_vld`, `sof`, `eof`, `frm_err`, `slip` and `slot_rst` is high in any cycle, and each of them is a single-cycle pulse.
- R11: While locked, a chip that breaks the preamble and is not a start-flag opening returns the block to hunt without any pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Receiver enable; low holds the block in hunt |
| slot_vld | input | 1 | A sampled timeslot is presented this cycle |
| slot_bit | input | 1 | Sampled pulse value of the timeslot |
| slot_idx | input | 2 | Slot index from timing recovery; 3 completes a chip |
| byte_vld | output | 1 | Decoded byte strobe |
| byte_data | output | 8 | Decoded byte, valid with `byte_vld` |
| sof | output | 1 | Start flag accepted |
| eof | output | 1 | Stop flag accepted, frame ended |
| frm_err | output | 1 | Framing error, frame abandoned |
| slip | output | 1 | Request to delay the slot count by one slot |
| slot_rst | output | 1 | Preamble lock; slot count is aligned |

## Verification
The block has no parameters, so the bench builds its single fixed configuration. The bench's slot source honours `slip` by repeating index 3, so a stream that starts one slot off the chip grid has to walk through many hunt attempts before it locks. This exercises every window phase the hunt can meet. The frames that follow cover good data, a broken start flag, a double-pulse data chip, a broken stop flag, a stray chip inside the preamble, and enable being dropped mid-frame.

// File: rtl/ppm4_hunt_decoder.sv
module ppm4_hunt_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       slot_vld,
  input  logic       slot_bit,
  input  logic [1:0] slot_idx,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       sof,
  output logic       eof,
  output logic       frm_err,
  output logic       slip,
  output logic       slot_rst
);

  typedef enum logic [2:0] {HUNT, LOCK, SFLG, DATA, STOP} st_t;

  localparam logic [15:0] PRE_SEQ = 16'b1000_0000_1010_1000;
  localparam logic [31:0] SOF_SEQ = 32'h0C0C_6060;
  localparam logic [31:0] EOF_SEQ = 32'h0C0C_0606;

  st_t        st;
  logic [2:0] sr;
  logic [2:0] cnt;
  logic [15:0] acc;

  wire       done    = en && slot_vld && (slot_idx == 2'd3);
  wire [3:0] chip    = {sr, slot_bit};
  wire       one_hot = $onehot(chip);
  wire [1:0] pair    = {chip[1] | chip[0], chip[2] | chip[0]};
  wire [4:0] fsh     = 5'd28 - {cnt, 2'b00};
  wire [3:0] pre_exp = PRE_SEQ[{~cnt[1:0], 2'b00} +: 4];
  wire [3:0] sof_exp = SOF_SEQ[fsh +: 4];
  wire [3:0] eof_exp = EOF_SEQ[fsh +: 4];

  always_ff @(posedge clk) begin
    byte_vld <= 1'b0;
    sof      <= 1'b0;
    eof      <= 1'b0;
    frm_err  <= 1'b0;
    slip     <= 1'b0;
    slot_rst <= 1'b0;
    if (!rst_n || !en) begin
      st  <= HUNT;
      cnt <= '0;
      sr  <= '0;
      acc <= '0;
      if (!rst_n) byte_data <= '0;
    end else begin
      if (slot_vld) sr <= {sr[1:0], slot_bit};
      if (done) begin
        case (st)
          HUNT: begin
            acc <= {acc[11:0], chip};
            if (cnt[1:0] == 2'd3) begin
              cnt <= '0;
              if ({acc[11:0], chip} == PRE_SEQ) begin
                st       <= LOCK;
                slot_rst <= 1'b1;
              end else begin
                slip <= 1'b1;
              end
            end else begin
              cnt <= cnt + 3'd1;
            end
          end
          LOCK: begin
            if (chip == pre_exp) begin
              cnt <= {1'b0, cnt[1:0] + 2'd1};
            end else if (cnt[1:0] == 2'd0 && chip == 4'd0) begin
              st  <= SFLG;
              cnt <= 3'd1;
            end else begin
              st  <= HUNT;
              cnt <= '0;
            end
          end
          SFLG, STOP: begin
            if (chip != (st == SFLG ? sof_exp : eof_exp)) begin
              frm_err <= 1'b1;
              st      <= HUNT;
              cnt     <= '0;
            end else if (cnt == 3'd7) begin
              cnt <= '0;
              if (st == SFLG) begin
                sof <= 1'b1;
                st  <= DATA;
              end else begin
                eof <= 1'b1;
                st  <= HUNT;
              end
            end else begin
              cnt <= cnt + 3'd1;
            end
          end
          DATA: begin
            if (one_hot) begin
              acc[{cnt[1:0], 1'b0} +: 2] <= pair;
              if (cnt[1:0] == 2'd3) begin
                byte_vld  <= 1'b1;
                byte_data <= {pair, acc[5:0]};
                cnt       <= '0;
              end else begin
                cnt <= cnt + 3'd1;
              end
            end else if (cnt == 3'd0 && chip == 4'd0) begin
              st  <= STOP;
              cnt <= 3'd1;
            end else begin
              frm_err <= 1'b1;
              st      <= HUNT;
              cnt     <= '0;
            end
          end
          default: begin
            st  <= HUNT;
            cnt <= '0;
          end
        endcase
      end
    end
  end

  // R10: pulses are mutually exclusive
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, sof, eof, frm_err, slip, slot_rst}));

  // R10: every pulse lasts a single cycle
  p_single_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld || sof || eof || frm_err || slip || slot_rst) |=>
      !(byte_vld || sof || eof || frm_err || slip || slot_rst));

  // R2 R3: alignment feedback only follows a completed chip
  p_slip_after_chip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slip || slot_rst) |-> $past(en && slot_vld && slot_idx == 2'd3));

  // R6: a byte only follows a completed chip
  p_byte_after_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(en && slot_vld && slot_idx == 2'd3));

  // R1: a disabled cycle produces no pulse
  p_quiet_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !(byte_vld || sof || eof || frm_err || slip || slot_rst));

  // R4 R8: start and stop flags need eight chips after a lock
  p_sof_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_rst |=> !sof);

endmodule

// File: tb/ppm4_hunt_decoder_tb.sv
module ppm4_hunt_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, slot_vld = 1'b0, slot_bit = 1'b0;
  logic [1:0] slot_idx = 2'd0;
  logic byte_vld, sof, eof, frm_err, slip, slot_rst;
  logic [7:0] byte_data;

  ppm4_hunt_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .slot_vld(slot_vld), .slot_bit(slot_bit),
    .slot_idx(slot_idx), .byte_vld(byte_vld), .byte_data(byte_data), .sof(sof),
    .eof(eof), .frm_err(frm_err), .slip(slip), .slot_rst(slot_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  int pre_c[4] = '{8, 0, 10, 8};
  int sof_c[8] = '{0, 12, 0, 12, 6, 0, 6, 0};
  int eof_c[8] = '{0, 12, 0, 12, 0, 6, 0, 6};

  int m_mode = 0, m_pos = 0, m_chip = 0, m_byte = 0, tidx = 0;
  int m_grp[$];
  bit e_byte, e_sof, e_eof, e_err, e_slip, e_rst;
  int e_data;
  int got_bytes[$];
  int n_rst = 0, n_eof = 0, n_err = 0, n_sof = 0;

  task automatic clear_exp();
    e_byte = 0; e_sof = 0; e_eof = 0; e_err = 0; e_slip = 0; e_rst = 0;
  endtask

  task automatic to_hunt();
    m_mode = 0; m_pos = 0; m_grp.delete();
  endtask

  function automatic int pair_of(int c);
    for (int k = 0; k < 4; k++) if (c == (8 >> k)) return k;
    return -1;
  endfunction

  task automatic model_chip(int c);
    int k;
    case (m_mode)
      0: begin
        m_grp.push_back(c);
        if (m_grp.size() == 4) begin
          if (m_grp[0] == pre_c[0] && m_grp[1] == pre_c[1] &&
              m_grp[2] == pre_c[2] && m_grp[3] == pre_c[3]) begin
            e_rst = 1; m_mode = 1; m_pos = 0;
          end else e_slip = 1;
          m_grp.delete();
        end
      end
      1: begin
        if (c == pre_c[m_pos]) m_pos = (m_pos + 1) % 4;
        else if (m_pos == 0 && c == 0) begin m_mode = 2; m_pos = 1; end
        else to_hunt();
      end
      2, 4: begin
        if (c != (m_mode == 2 ? sof_c[m_pos] : eof_c[m_pos])) begin e_err = 1; to_hunt(); end
        else if (m_pos == 7) begin
          if (m_mode == 2) begin e_sof = 1; m_mode = 3; m_pos = 0; m_byte = 0; end
          else begin e_eof = 1; to_hunt(); end
        end else m_pos++;
      end
      default: begin
        k = pair_of(c);
        if (k >= 0) begin
          m_byte |= k << (2 * m_pos);
          if (m_pos == 3) begin e_byte = 1; e_data = m_byte; m_byte = 0; m_pos = 0; end
          else m_pos++;
        end else if (c == 0 && m_pos == 0) begin m_mode = 4; m_pos = 1; end
        else begin e_err = 1; to_hunt(); end
      end
    endcase
  endtask

  task automatic cmp1(string req, logic act, bit exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    vectors++;
    cmp1("R2 slip", slip, e_slip);
    cmp1("R3 slot_rst", slot_rst, e_rst);
    cmp1("R4 sof", sof, e_sof);
    cmp1("R5 R7 R9 frm_err", frm_err, e_err);
    cmp1("R6 byte_vld", byte_vld, e_byte);
    cmp1("R8 eof", eof, e_eof);
    if (e_byte && byte_vld === 1'b1 && byte_data !== e_data[7:0]) begin
      miscompares++;
      $display("FAIL R6 byte_data: actual %02h expected %02h", byte_data, e_data[7:0]);
    end
    if (byte_vld === 1'b1) got_bytes.push_back(int'(byte_data));
    if (slot_rst === 1'b1) n_rst++;
    if (eof === 1'b1) n_eof++;
    if (frm_err === 1'b1) n_err++;
    if (sof === 1'b1) n_sof++;
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_en(bit v);
    en = v;
    if (!v) begin to_hunt(); m_chip = 0; end
  endtask

  task automatic slot(bit b);
    bit s;
    slot_vld = 1; slot_bit = b; slot_idx = 2'(tidx);
    clear_exp();
    if (en) begin
      m_chip = ((m_chip << 1) | int'(b)) & 15;
      if (tidx == 3) model_chip(m_chip);
    end
    @(negedge clk);
    compare();
    s = e_slip;
    if (!s) tidx = (tidx + 1) % 4;
    if (e_rst) tidx = 0;
    slot_vld = 0;
    clear_exp();
    @(negedge clk);
    compare();
  endtask

  task automatic send_chip(int c);
    for (int i = 3; i >= 0; i--) slot(c[i]);
  endtask

  task automatic send_pre(int n);
    for (int r = 0; r < n; r++) for (int i = 0; i < 4; i++) send_chip(pre_c[i]);
  endtask

  task automatic send_sof();
    for (int i = 0; i < 8; i++) send_chip(sof_c[i]);
  endtask

  task automatic send_eof();
    for (int i = 0; i < 8; i++) send_chip(eof_c[i]);
  endtask

  task automatic send_byte(int b);
    for (int i = 0; i < 4; i++) send_chip(8 >> ((b >> (2 * i)) & 3));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_exp();
    repeat (3) @(negedge clk);
    compare(); // R1 reset state
    rst_n = 1;
    @(negedge clk);
    compare();

    // R1: slots while disabled are ignored
    send_pre(2);
    check("R1 no lock while disabled", n_rst, 0);

    // R2 R3 R4 R6 R8: off-grid start, long preamble, good frame
    set_en(1);
    slot(0);
    send_pre(40);
    check("R3 single lock through repeats", n_rst, 1);
    check("R3 no error through repeats", n_err, 0);
    send_sof();
    check("R4 sof seen", n_sof, 1);
    got_bytes.delete();
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF); send_byte(8'h00);
    send_eof();
    check("R6 byte count", got_bytes.size(), 4);
    if (got_bytes.size() == 4) begin
      check("R6 byte 0", got_bytes[0], 8'hA5);
      check("R6 byte 3", got_bytes[3], 8'h00);
    end
    check("R8 eof seen", n_eof, 1);

    // R5: start flag broken at its third chip
    n_err = 0;
    send_pre(17);
    send_chip(0); send_chip(12); send_chip(8);
    check("R5 start flag error", n_err, 1);

    // R7: double-pulse data chip
    n_err = 0; n_sof = 0;
    send_pre(17); send_sof(); send_byte(8'h5A);
    send_chip(12);
    check("R7 invalid chip error", n_err, 1);

    // R9: stop flag broken at fifth chip
    n_err = 0; n_eof = 0;
    send_pre(17); send_sof(); send_byte(8'h12);
    send_chip(0); send_chip(12); send_chip(0); send_chip(12); send_chip(1);
    check("R9 stop flag error", n_err, 1);
    check("R9 no eof", n_eof, 0);

    // R11: stray chip inside preamble, then relock
    n_err = 0; n_rst = 0;
    send_pre(17); send_chip(4);
    send_pre(20);
    check("R11 no error on stray chip", n_err, 0);
    check("R11 relocked", n_rst >= 1 ? 1 : 0, 1);

    // R1: enable dropped mid-frame, then a clean frame
    send_sof(); send_byte(8'h77);
    set_en(0);
    send_byte(8'h99);
    set_en(1);
    got_bytes.delete(); n_eof = 0;
    send_pre(20); send_sof(); send_byte(8'hC3); send_eof();
    check("R1 frame after re-enable", got_bytes.size(), 1);
    if (got_bytes.size() == 1) check("R6 byte after re-enable", got_bytes[0], 8'hC3);
    check("R8 eof after re-enable", n_eof, 1);

    finish_run();
  end
endmodule